// File: doc/BRIEF.md
# FIFO-Replacement Tag Store

This block is a small fully associative tag store. It holds up to `FRAMES` block numbers and replaces them in arrival order. Each access carries a block number. The block compares it with every occupied frame in parallel. A match is reported as a hit and changes nothing else. A mismatch is reported as a miss. The new block number then goes either into the next empty frame or, when every frame is full, into the frame whose block arrived first. A circular arrival pointer picks that frame.

Two saturating counters keep running totals of hits and misses. Because the capacity is a parameter, one access stream can drive stores of different sizes side by side. This shows how the miss total depends on size, including the case where a larger first-in-first-out store misses more often than a smaller one.

Accesses enter on a valid/ready stream and results leave on a valid/ready stream. An access is taken on a clock edge where `acc_valid` and `acc_ready` are both high. Its result is held in a one-entry output register until `rsp_ready` takes it. While a result is waiting and `rsp_ready` is low, `acc_ready` stays low, so a stalled consumer holds back the producer. With `rsp_ready` held high, the store accepts one access every cycle.

Top module: `fifo_tag_store`

## Requirements
- R1: While reset is asserted and after it is released, no frame is occupied, both counters read 0, `rsp_valid` is 0 and `acc_ready` is 1.
- R2: The result of an access is on `rsp_valid`/`rsp_hit` in the cycle after it is accepted. `rsp_hit` is 1 exactly when the block number matches an occupied frame.
- R3: A miss while some frame is empty fills an empty frame and evicts nothing: every block number accepted before it still hits.
- R4: A miss while all frames are full replaces the block that arrived earliest. A hit does not change arrival order, so a block that was just hit can still be the next one evicted.
- R5: `hit_count` and `miss_count` are 16 bits wide. Each accepted access adds 1 to exactly one of them, on the same edge as the result. Each counter holds at 65535 instead of wrapping.
- R6: While `rsp_valid` is 1 and `rsp_ready` is 0, `acc_ready` is 0, no access is taken, and `rsp_hit` and both counters stay unchanged.
- R7: On the block sequence 1,2,3,4,1,2,5,1,2,3,4,5 starting from reset, a 3-frame store ends with 9 misses and 3 hits, and a 4-frame store ends with 10 misses and 2 hits.
- R8: When a repeating set of distinct block numbers is no larger than the capacity, only the first access to each of them misses.
- R9: Every tag value, including all-ones, is an ordinary block number. Occupancy is held in a separate valid bit per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Access present |
| acc_ready | output | 1 | Store can take an access this cycle |
| acc_tag | input | TAG_W | Block number of the access |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| hit_count | output | CNT_W | Saturating hit total |
| miss_count | output | CNT_W | Saturating miss total |

## Verification
The hit/miss result and both counters come from registers loaded on the edge that accepts the access, so all three are due exactly one cycle after acceptance. The bench drives each access at a falling edge and checks the result and counters at the next falling edge, one rising edge later. It keeps a model of arrival order for a 4-frame and a 3-frame store that receive the same stream. During stalls it checks that the outputs stay frozen over several cycles. In the saturation run, accesses are back to back and the totals are checked after the stream stops.

// File: rtl/fifo_tag_pkg.sv
package fifo_tag_pkg;
  // Default widths shared by the store and its checker
  localparam int unsigned DEF_TAG_W = 8;
  localparam int unsigned DEF_CNT_W = 16;

  // Width of a frame pointer for a given capacity
  function automatic int unsigned ptr_width(input int unsigned frames);
    return (frames > 1) ? $clog2(frames) : 1;
  endfunction
endpackage

// File: rtl/fts_match.sv
module fts_match #(
  parameter int unsigned FRAMES = 4,
  parameter int unsigned TAG_W  = 8
) (
  input  logic [FRAMES-1:0]            occupied,
  input  logic [FRAMES-1:0][TAG_W-1:0] stored,
  input  logic [TAG_W-1:0]             probe,
  output logic                         hit
);
  logic [FRAMES-1:0] eq;

  // One comparator per frame, all in parallel
  for (genvar f = 0; f < FRAMES; f++) begin : g_cmp
    assign eq[f] = occupied[f] && (stored[f] == probe);
  end

  assign hit = |eq;
endmodule

// File: rtl/fts_sat_ctr.sv
module fts_sat_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                  value <= '0;
    else if (inc && value != TOP) value <= value + 1'b1;
  end
endmodule

// File: rtl/fifo_tag_store.sv
module fifo_tag_store
  import fifo_tag_pkg::*;
#(
  parameter int unsigned FRAMES = 4,
  parameter int unsigned TAG_W  = DEF_TAG_W,
  parameter int unsigned CNT_W  = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic [TAG_W-1:0] acc_tag,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int unsigned PTR_W = ptr_width(FRAMES);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(FRAMES - 1);

  logic [FRAMES-1:0]            occ_q;
  logic [FRAMES-1:0][TAG_W-1:0] tag_q;
  logic [PTR_W-1:0]             arr_ptr_q;
  logic                         found;
  logic                         take;

  // The output register can take a new result if it is empty or being drained
  assign acc_ready = !rsp_valid || rsp_ready;
  assign take      = acc_valid && acc_ready;

  fts_match #(.FRAMES(FRAMES), .TAG_W(TAG_W)) u_match (
    .occupied (occ_q),
    .stored   (tag_q),
    .probe    (acc_tag),
    .hit      (found)
  );

  // Frames fill in pointer order and are never freed, so the arrival
  // pointer is both the next empty frame and the oldest full one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q     <= '0;
      tag_q     <= '0;
      arr_ptr_q <= '0;
    end else if (take && !found) begin
      occ_q[arr_ptr_q] <= 1'b1;
      tag_q[arr_ptr_q] <= acc_tag;
      arr_ptr_q        <= (arr_ptr_q == LAST) ? '0 : arr_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= found;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  fts_sat_ctr #(.CNT_W(CNT_W)) u_hits (
    .clk (clk), .rst_n (rst_n), .inc (take && found), .value (hit_count)
  );

  fts_sat_ctr #(.CNT_W(CNT_W)) u_misses (
    .clk (clk), .rst_n (rst_n), .inc (take && !found), .value (miss_count)
  );
endmodule

// File: rtl/fifo_tag_store_chk.sv
module fifo_tag_store_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic take;
  assign take = acc_valid && acc_ready;

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (hit_count == '0 && miss_count == '0 && !rsp_valid));

  a_r2_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  a_r5_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && miss_count != TOP) |=> (rsp_hit || miss_count == $past(miss_count) + 1'b1));

  a_r5_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit_count != TOP) |=> (!rsp_hit || hit_count == $past(hit_count) + 1'b1));

  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(hit_count) && $stable(miss_count)));

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count == TOP) |=> (miss_count == TOP));

  a_r6_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !acc_ready);

  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)));
endmodule

bind fifo_tag_store fifo_tag_store_chk #(.CNT_W(CNT_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid), .acc_ready (acc_ready),
  .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_hit (rsp_hit),
  .hit_count (hit_count), .miss_count (miss_count)
);

// File: tb/fifo_tag_store_tb.sv
module fifo_tag_store_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [7:0] acc_tag = '0;
  logic       rsp_ready = 1'b1;
  logic [1:0] acc_ready, rsp_valid, rsp_hit;
  logic [15:0] hcnt [2];
  logic [15:0] mcnt [2];

  always #10 clk = ~clk; // 50 MHz

  fifo_tag_store #(.FRAMES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready[0]),
    .acc_tag(acc_tag), .rsp_valid(rsp_valid[0]), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit[0]), .hit_count(hcnt[0]), .miss_count(mcnt[0]));

  fifo_tag_store #(.FRAMES(3)) u_dut3 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready[1]),
    .acc_tag(acc_tag), .rsp_valid(rsp_valid[1]), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit[1]), .hit_count(hcnt[1]), .miss_count(mcnt[1]));

  int checks = 0;
  int fails = 0;

  // Reference model: index 0 = 4 frames, index 1 = 3 frames
  int   cap [2] = '{4, 3};
  logic [7:0] m_tag [2][4];
  bit   m_val [2][4];
  int   m_ptr [2];
  int   e_hit [2];
  int   e_miss [2];

  function automatic void model_clear();
    for (int d = 0; d < 2; d++) begin
      for (int f = 0; f < 4; f++) begin m_val[d][f] = 0; m_tag[d][f] = '0; end
      m_ptr[d] = 0; e_hit[d] = 0; e_miss[d] = 0;
    end
  endfunction

  function automatic bit model_access(int d, logic [7:0] t);
    for (int f = 0; f < cap[d]; f++)
      if (m_val[d][f] && m_tag[d][f] == t) begin
        if (e_hit[d] < 65535) e_hit[d]++;
        return 1'b1;
      end
    m_val[d][m_ptr[d]] = 1; m_tag[d][m_ptr[d]] = t;
    m_ptr[d] = (m_ptr[d] + 1) % cap[d];
    if (e_miss[d] < 65535) e_miss[d]++;
    return 1'b0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; acc_valid = 1'b0; rsp_ready = 1'b1;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One access; returns nothing, checks result and counters on both stores
  task automatic access(logic [7:0] t, string req);
    bit eh [2];
    @(negedge clk); acc_valid = 1'b1; acc_tag = t; rsp_ready = 1'b1;
    for (int d = 0; d < 2; d++) eh[d] = model_access(d, t);
    @(negedge clk); acc_valid = 1'b0;
    for (int d = 0; d < 2; d++) begin
      check({req, " rsp_valid"}, int'(rsp_valid[d]), 1);
      check({req, " hit"}, int'(rsp_hit[d]), int'(eh[d]));
      check({req, " R5 hits"}, int'(hcnt[d]), e_hit[d]);
      check({req, " R5 misses"}, int'(mcnt[d]), e_miss[d]);
    end
  endtask

  // Directed access on the 4-frame store with a fixed expected result
  task automatic access_exp4(logic [7:0] t, bit exp, string req);
    access(t, req);
    check({req, " directed"}, int'(rsp_hit[0]), int'(exp));
  endtask

  int trace [12] = '{1, 2, 3, 4, 1, 2, 5, 1, 2, 3, 4, 5};

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      check("R1 rsp_valid", int'(rsp_valid[d]), 0);
      check("R1 acc_ready", int'(acc_ready[d]), 1);
      check("R1 hits", int'(hcnt[d]), 0);
      check("R1 misses", int'(mcnt[d]), 0);
    end

    // R7: size-dependent miss totals
    for (int i = 0; i < 12; i++) access(8'(trace[i]), "R2 R7 trace");
    check("R7 3-frame misses", int'(mcnt[1]), 9);
    check("R7 3-frame hits", int'(hcnt[1]), 3);
    check("R7 4-frame misses", int'(mcnt[0]), 10);
    check("R7 4-frame hits", int'(hcnt[0]), 2);

    // R3 cold fills, R9 all-ones tag, R4 oldest evicted despite a hit
    do_reset();
    access_exp4(8'd0,   1'b0, "R3 fill");
    access_exp4(8'd255, 1'b0, "R9 fill all-ones");
    access_exp4(8'd0,   1'b1, "R3 kept");
    access_exp4(8'd255, 1'b1, "R9 all-ones hits");
    access_exp4(8'd10,  1'b0, "R3 fill");
    access_exp4(8'd11,  1'b0, "R3 fill last");
    access_exp4(8'd0,   1'b1, "R4 hit on oldest");
    access_exp4(8'd12,  1'b0, "R4 evicting miss");
    access_exp4(8'd0,   1'b0, "R4 oldest gone");
    access_exp4(8'd10,  1'b1, "R4 younger kept");

    // R8: working set within capacity
    do_reset();
    for (int p = 0; p < 5; p++)
      for (int k = 0; k < 3; k++) access(8'(20 + k), "R8 loop");
    check("R8 4-frame misses", int'(mcnt[0]), 3);
    check("R8 3-frame misses", int'(mcnt[1]), 3);

    // Random stream against the model
    do_reset();
    for (int i = 0; i < 300; i++) begin
      int r = $urandom % 7;
      access((r == 6) ? 8'hFF : 8'(r), "R2 R4 random");
    end

    // R6: back-pressure
    @(negedge clk); acc_valid = 1'b1; acc_tag = 8'd3; rsp_ready = 1'b0;
    for (int d = 0; d < 2; d++) void'(model_access(d, 8'd3));
    @(negedge clk); acc_tag = 8'd77;
    for (int c = 0; c < 3; c++) begin
      for (int d = 0; d < 2; d++) begin
        check("R6 acc_ready low", int'(acc_ready[d]), 0);
        check("R6 rsp_valid held", int'(rsp_valid[d]), 1);
        check("R6 misses frozen", int'(mcnt[d]), e_miss[d]);
        check("R6 hits frozen", int'(hcnt[d]), e_hit[d]);
      end
      @(negedge clk);
    end
    acc_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    check("R6 drained", int'(rsp_valid[0]), 0);
    access(8'd77, "R6 stalled tag was not stored");

    // R5: miss saturation with back-to-back accesses cycling five tags
    @(negedge clk); acc_valid = 1'b1; rsp_ready = 1'b1;
    for (int i = 0; i < 65540; i++) begin
      acc_tag = 8'(100 + i % 5);
      @(negedge clk);
    end
    acc_valid = 1'b0;
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      check("R5 miss saturates", int'(mcnt[d]), 65535);
      check("R5 hits untouched", int'(hcnt[d]), e_hit[d]);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule